// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sequences a small processor system into and out of its low-power states. Software sets two control bits: a standby enable and a deep-mode select. When the processor reports that its sleep instruction has executed, the block reads those two bits and selects one of three depths.

- **Light sleep** stops only the CPU clock.
- **Software standby** also stops the peripherals and the clock generator. It keeps every memory's contents.
- **Deep standby** also removes power from the high-speed RAM. Only the retention RAM keeps its data.

For each depth the block drives the per-domain halt, hold and power lines. It also sets the external-memory refresh style. Each depth has its own set of qualified wake sources.

On wake from light sleep the CPU resumes at once. On wake from either standby depth, the block first waits a programmable number of clock-stabilisation cycles. It then releases the CPU clock and requests auto-refresh from the memory controller. A deep exit ends with a restart pulse, because CPU state has been lost. A sleep or software-standby exit ends with a resume pulse.

Top module: `pwrdn_ctrl`

## Requirements
- R1: A sleep request in the running state with the standby-enable bit at 0 enters light sleep (`mode_o` = 2'b01), whatever the deep bit holds.
- R2: A sleep request with standby-enable 1 and deep 0 enters software standby (`mode_o` = 2'b10).
- R3: A sleep request with standby-enable 1 and deep 1 enters deep standby (`mode_o` = 2'b11).
- R4: In light sleep only `cpu_clk_halt_o` is high among the halts. `hsram_pwr_o` stays 1, the hold outputs stay 0 and `self_refresh_o` stays 0 (auto-refresh).
- R5: In software standby all three halts are 1, `hsram_hold_o`, `hsram_pwr_o` and `retram_hold_o` are 1, and `self_refresh_o` is 1.
- R6: In deep standby all three halts are 1, `hsram_pwr_o` and `hsram_hold_o` are 0, `retram_hold_o` is 1, and `self_refresh_o` is 1.
- R7: Light sleep is left on any of `irq_any_i`, `nmi_i`, `ext_irq_i`, `dma_addr_err_i` or `man_rst_i`. The block is back in the running state (mode 2'b00) one clock after the wake is sampled, with `resume_o` high for exactly that one cycle.
- R8: In either standby depth, `irq_any_i` and `dma_addr_err_i` have no effect: the mode and the domain outputs are unchanged.
- R9: In either standby depth, `nmi_i`, `ext_irq_i` or `man_rst_i` starts a settle phase lasting N cycles, where N is `settle_cycles_i` sampled at the wake and 0 counts as 1. During the settle phase:
  - `cpu_clk_halt_o` and `per_clk_halt_o` stay 1;
  - `cpg_halt_o` is 0;
  - `self_refresh_o` stays 1;
  - `mode_o` still shows the depth being left.

  After the settle phase the block is running, and `autoref_req_o` pulses for one cycle.
- R10: The end of a deep-standby exit pulses `restart_o` and not `resume_o`. The end of a software-standby exit pulses `resume_o` and not `restart_o`.
- R11: `sleep_req_i` is ignored in any state other than running.
- R12: After reset the block is running: mode 2'b00, all halts, holds, self-refresh and pulses are 0, and `hsram_pwr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stby_en_i | input | 1 | Standby-enable control bit |
| deep_i | input | 1 | Deep-mode control bit |
| sleep_req_i | input | 1 | Sleep instruction executed (one-cycle pulse) |
| irq_any_i | input | 1 | Any pending maskable interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| ext_irq_i | input | 1 | External interrupt pin request |
| dma_addr_err_i | input | 1 | DMA address error |
| man_rst_i | input | 1 | Manual reset request |
| settle_cycles_i | input | CNT_W | Clock-stabilisation wait in cycles |
| mode_o | output | 2 | Current depth: 00 run, 01 sleep, 10 software standby, 11 deep |
| cpu_clk_halt_o | output | 1 | CPU clock stopped |
| per_clk_halt_o | output | 1 | Peripheral clocks stopped |
| cpg_halt_o | output | 1 | Clock generator stopped |
| hsram_hold_o | output | 1 | High-speed RAM halted with contents kept |
| hsram_pwr_o | output | 1 | High-speed RAM powered |
| retram_hold_o | output | 1 | Retention RAM halted with contents kept |
| self_refresh_o | output | 1 | External memory in self-refresh (0 = auto-refresh) |
| autoref_req_o | output | 1 | One-cycle request to return to auto-refresh |
| resume_o | output | 1 | One-cycle pulse: continue execution |
| restart_o | output | 1 | One-cycle pulse: restart after state loss |

## Verification
The state register is the only stage between a sampled input and the mode and domain outputs. A sleep request or wake driven before a rising edge is therefore visible just after that edge. The resume, restart and auto-refresh pulses are registered at the same edge that returns the block to running.

A standby wake puts the block into settle at the first edge. The block then stays there for N sampled cycles, and the pulses appear after edge N+1 counted from the wake. The bench drives on falling edges and samples on the next falling edge after every single step. The settle loops check each of the N cycles, and the cycle after the pulse is checked to show it has dropped.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_SSTBY  = 3'd2,
    ST_DSTBY  = 3'd3,
    ST_SETTLE = 3'd4
  } pd_state_e;

  typedef enum logic [1:0] {
    MD_RUN   = 2'b00,
    MD_SLEEP = 2'b01,
    MD_SSTBY = 2'b10,
    MD_DSTBY = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic cpu_halt;
    logic per_halt;
    logic cpg_halt;
    logic hs_hold;
    logic hs_pwr;
    logic ret_hold;
    logic self_ref;
  } dom_ctl_t;

  typedef struct packed {
    logic any_irq;
    logic nmi;
    logic ext_irq;
    logic dma_err;
    logic man_rst;
  } wake_t;

endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual
  import pwrdn_pkg::*;
(
  input  pd_state_e state,
  input  wake_t     src,
  output logic      wake_hit
);

  logic strong_src;

  // Only non-maskable, pin interrupts and manual reset reach the standby depths
  assign strong_src = src.nmi | src.ext_irq | src.man_rst;

  always_comb begin
    unique case (state)
      ST_SLEEP:           wake_hit = |src;
      ST_SSTBY, ST_DSTBY: wake_hit = strong_src;
      default:            wake_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwrdn_settle_cnt.sv
module pwrdn_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q <= ONE);
  assign cnt_en = load | (active & ~done);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val;
    else if (active && !done) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: while the wait runs, the count falls by one each cycle
  assert_settle_count_down_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && !done && !load) |=> (cnt_q == $past(cnt_q) - ONE))
    else $error("settle counter did not step down");

endmodule

// File: rtl/pwrdn_domain_map.sv
module pwrdn_domain_map
  import pwrdn_pkg::*;
(
  input  pd_state_e state,
  input  logic      deep_exit,
  output dom_ctl_t  dom
);

  always_comb begin
    dom = '{cpu_halt: 1'b0, per_halt: 1'b0, cpg_halt: 1'b0, hs_hold: 1'b0,
            hs_pwr: 1'b1, ret_hold: 1'b0, self_ref: 1'b0};
    unique case (state)
      ST_RUN: ;
      ST_SLEEP: dom.cpu_halt = 1'b1;
      ST_SSTBY: begin
        dom.cpu_halt = 1'b1;
        dom.per_halt = 1'b1;
        dom.cpg_halt = 1'b1;
        dom.hs_hold  = 1'b1;
        dom.ret_hold = 1'b1;
        dom.self_ref = 1'b1;
      end
      ST_DSTBY: begin
        dom.cpu_halt = 1'b1;
        dom.per_halt = 1'b1;
        dom.cpg_halt = 1'b1;
        dom.hs_pwr   = 1'b0;
        dom.ret_hold = 1'b1;
        dom.self_ref = 1'b1;
      end
      ST_SETTLE: begin
        // clock generator restarted, everything else waits for it
        dom.cpu_halt = 1'b1;
        dom.per_halt = 1'b1;
        dom.hs_hold  = ~deep_exit;
        dom.ret_hold = 1'b1;
        dom.self_ref = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_en_i,
  input  logic             deep_i,
  input  logic             sleep_req_i,
  input  logic             irq_any_i,
  input  logic             nmi_i,
  input  logic             ext_irq_i,
  input  logic             dma_addr_err_i,
  input  logic             man_rst_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_halt_o,
  output logic             per_clk_halt_o,
  output logic             cpg_halt_o,
  output logic             hsram_hold_o,
  output logic             hsram_pwr_o,
  output logic             retram_hold_o,
  output logic             self_refresh_o,
  output logic             autoref_req_o,
  output logic             resume_o,
  output logic             restart_o
);

  logic      rst_ns;
  pd_state_e state_q, state_d;
  logic      deep_exit_q, deep_exit_d;
  logic      resume_q, resume_d;
  logic      restart_q, restart_d;
  logic      autoref_q, autoref_d;
  logic      wake_hit;
  logic      cnt_load;
  logic      cnt_done;
  logic      in_settle;
  wake_t     wake_src;
  dom_ctl_t  dom;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign wake_src = '{any_irq: irq_any_i, nmi: nmi_i, ext_irq: ext_irq_i,
                      dma_err: dma_addr_err_i, man_rst: man_rst_i};

  pwrdn_wake_qual u_wake_qual (
    .state    (state_q),
    .src      (wake_src),
    .wake_hit (wake_hit)
  );

  assign in_settle = (state_q == ST_SETTLE);

  pwrdn_settle_cnt #(.CNT_W(CNT_W)) u_settle_cnt (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .load     (cnt_load),
    .load_val (settle_cycles_i),
    .active   (in_settle),
    .done     (cnt_done)
  );

  pwrdn_domain_map u_domain_map (
    .state     (state_q),
    .deep_exit (deep_exit_q),
    .dom       (dom)
  );

  // next-state process
  always_comb begin
    state_d     = state_q;
    deep_exit_d = deep_exit_q;
    resume_d    = 1'b0;
    restart_d   = 1'b0;
    autoref_d   = 1'b0;
    cnt_load    = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req_i) begin
          if (!stby_en_i)  state_d = ST_SLEEP;
          else if (deep_i) state_d = ST_DSTBY;
          else             state_d = ST_SSTBY;
        end
      end
      ST_SLEEP: begin
        if (wake_hit) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
        end
      end
      ST_SSTBY, ST_DSTBY: begin
        if (wake_hit) begin
          state_d     = ST_SETTLE;
          deep_exit_d = (state_q == ST_DSTBY);
          cnt_load    = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt_done) begin
          state_d   = ST_RUN;
          autoref_d = 1'b1;
          resume_d  = ~deep_exit_q;
          restart_d = deep_exit_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q     <= ST_RUN;
      deep_exit_q <= 1'b0;
      resume_q    <= 1'b0;
      restart_q   <= 1'b0;
      autoref_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      deep_exit_q <= deep_exit_d;
      resume_q    <= resume_d;
      restart_q   <= restart_d;
      autoref_q   <= autoref_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP:  mode_o = MD_SLEEP;
      ST_SSTBY:  mode_o = MD_SSTBY;
      ST_DSTBY:  mode_o = MD_DSTBY;
      ST_SETTLE: mode_o = deep_exit_q ? MD_DSTBY : MD_SSTBY;
      default:   mode_o = MD_RUN;
    endcase
  end

  assign cpu_clk_halt_o = dom.cpu_halt;
  assign per_clk_halt_o = dom.per_halt;
  assign cpg_halt_o     = dom.cpg_halt;
  assign hsram_hold_o   = dom.hs_hold;
  assign hsram_pwr_o    = dom.hs_pwr;
  assign retram_hold_o  = dom.ret_hold;
  assign self_refresh_o = dom.self_ref;
  assign autoref_req_o  = autoref_q;
  assign resume_o       = resume_q;
  assign restart_o      = restart_q;

  // R1: standby disabled selects light sleep
  assert_sleep_select_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_o == MD_RUN && !in_settle && sleep_req_i && !stby_en_i) |=> (mode_o == MD_SLEEP))
    else $error("light sleep not entered");

  // R2: software standby selection
  assert_sstby_select_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_o == MD_RUN && sleep_req_i && stby_en_i && !deep_i) |=> (mode_o == MD_SSTBY))
    else $error("software standby not entered");

  // R3: deep standby selection
  assert_dstby_select_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_o == MD_RUN && sleep_req_i && stby_en_i && deep_i) |=> (mode_o == MD_DSTBY))
    else $error("deep standby not entered");

  // R4: light sleep keeps the clock generator and peripherals alive
  assert_sleep_domains_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_o == MD_SLEEP) |-> (cpu_clk_halt_o && !per_clk_halt_o && !cpg_halt_o && !self_refresh_o))
    else $error("light sleep domains wrong");

  // R6: deep standby removes high-speed RAM power
  assert_deep_power_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_DSTBY) |-> (!hsram_pwr_o && retram_hold_o && self_refresh_o))
    else $error("deep standby domains wrong");

  // R8: weak wake sources leave standby untouched
  assert_standby_ignore_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    ((state_q == ST_SSTBY || state_q == ST_DSTBY) && !nmi_i && !ext_irq_i && !man_rst_i)
      |=> (state_q == $past(state_q)))
    else $error("standby left on a weak source");

  // R9: auto-refresh is only requested as a settle phase ends
  assert_autoref_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    autoref_req_o |-> ($past(in_settle) && mode_o == MD_RUN))
    else $error("auto-refresh request outside settle end");

  // R10: resume and restart never coincide
  assert_exit_kind_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    !(resume_o && restart_o))
    else $error("resume and restart together");

  // R11: sleep request has no effect outside the running state
  assert_req_ignored_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_SLEEP && sleep_req_i && !wake_hit) |=> (state_q == ST_SLEEP))
    else $error("sleep request acted outside run");

endmodule

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stby_en_i, deep_i, sleep_req_i;
  logic             irq_any_i, nmi_i, ext_irq_i, dma_addr_err_i, man_rst_i;
  logic [CNT_W-1:0] settle_cycles_i;
  logic [1:0]       mode_o;
  logic             cpu_clk_halt_o, per_clk_halt_o, cpg_halt_o;
  logic             hsram_hold_o, hsram_pwr_o, retram_hold_o, self_refresh_o;
  logic             autoref_req_o, resume_o, restart_o;

  int n_checks = 0;
  int n_fail   = 0;

  // domain bundle order: cpu, per, cpg, hs_hold, hs_pwr, ret_hold, self_ref
  localparam logic [6:0] D_RUN    = 7'b0000100;
  localparam logic [6:0] D_SLEEP  = 7'b1000100;
  localparam logic [6:0] D_SSTBY  = 7'b1111111;
  localparam logic [6:0] D_DSTBY  = 7'b1110011;
  localparam logic [6:0] D_SET_SW = 7'b1101111;
  localparam logic [6:0] D_SET_DP = 7'b1100111;

  always #10 clk = ~clk;

  pwrdn_ctrl #(.CNT_W(CNT_W)) i_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .stby_en_i(stby_en_i), .deep_i(deep_i),
    .sleep_req_i(sleep_req_i), .irq_any_i(irq_any_i), .nmi_i(nmi_i),
    .ext_irq_i(ext_irq_i), .dma_addr_err_i(dma_addr_err_i), .man_rst_i(man_rst_i),
    .settle_cycles_i(settle_cycles_i), .mode_o(mode_o),
    .cpu_clk_halt_o(cpu_clk_halt_o), .per_clk_halt_o(per_clk_halt_o),
    .cpg_halt_o(cpg_halt_o), .hsram_hold_o(hsram_hold_o), .hsram_pwr_o(hsram_pwr_o),
    .retram_hold_o(retram_hold_o), .self_refresh_o(self_refresh_o),
    .autoref_req_o(autoref_req_o), .resume_o(resume_o), .restart_o(restart_o)
  );

  function automatic logic [6:0] dom_now();
    return {cpu_clk_halt_o, per_clk_halt_o, cpg_halt_o, hsram_hold_o,
            hsram_pwr_o, retram_hold_o, self_refresh_o};
  endfunction

  function automatic logic [2:0] pulses_now();
    return {autoref_req_o, resume_o, restart_o};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request_sleep(input logic sb, input logic dp);
    stby_en_i   = sb;
    deep_i      = dp;
    sleep_req_i = 1'b1;
    step();
    sleep_req_i = 1'b0;
  endtask

  // 0 any_irq, 1 nmi, 2 ext_irq, 3 dma error, 4 manual reset
  task automatic pulse_wake(input int src);
    case (src)
      0: irq_any_i = 1'b1;
      1: nmi_i = 1'b1;
      2: ext_irq_i = 1'b1;
      3: dma_addr_err_i = 1'b1;
      default: man_rst_i = 1'b1;
    endcase
    step();
    irq_any_i = 1'b0; nmi_i = 1'b0; ext_irq_i = 1'b0;
    dma_addr_err_i = 1'b0; man_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    stby_en_i = 0; deep_i = 0; sleep_req_i = 0;
    irq_any_i = 0; nmi_i = 0; ext_irq_i = 0; dma_addr_err_i = 0; man_rst_i = 0;
    settle_cycles_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    check("R12", "mode", 32'(mode_o), 32'(2'b00));
    check("R12", "domains", 32'(dom_now()), 32'(D_RUN));
    check("R12", "pulses", 32'(pulses_now()), 32'(3'b000));
  endtask

  task automatic t_light_sleep();
    for (int src = 0; src < 5; src++) begin
      request_sleep(1'b0, src[0]);
      check("R1", "mode after request", 32'(mode_o), 32'(2'b01));
      check("R4", "sleep domains", 32'(dom_now()), 32'(D_SLEEP));
      if (src == 2) begin
        request_sleep(1'b1, 1'b1);
        check("R11", "request in sleep ignored", 32'(mode_o), 32'(2'b01));
      end
      pulse_wake(src);
      check("R7", "mode after wake", 32'(mode_o), 32'(2'b00));
      check("R7", "resume pulse", 32'(pulses_now()), 32'(3'b010));
      step();
      check("R7", "resume drops", 32'(pulses_now()), 32'(3'b000));
    end
  endtask

  task automatic t_sw_standby(input int n, input int src);
    settle_cycles_i = CNT_W'(n);
    request_sleep(1'b1, 1'b0);
    check("R2", "mode", 32'(mode_o), 32'(2'b10));
    check("R5", "domains", 32'(dom_now()), 32'(D_SSTBY));
    pulse_wake(0);
    check("R8", "irq ignored mode", 32'(mode_o), 32'(2'b10));
    check("R8", "irq ignored domains", 32'(dom_now()), 32'(D_SSTBY));
    pulse_wake(3);
    check("R8", "dma error ignored", 32'(dom_now()), 32'(D_SSTBY));
    request_sleep(1'b0, 1'b0);
    check("R11", "request in standby ignored", 32'(mode_o), 32'(2'b10));
    pulse_wake(src);
    for (int k = 1; k <= ((n == 0) ? 1 : n); k++) begin
      if (k > 1) step();
      check("R9", "settle domains", 32'(dom_now()), 32'(D_SET_SW));
      check("R9", "settle mode", 32'(mode_o), 32'(2'b10));
      check("R9", "no pulse in settle", 32'(pulses_now()), 32'(3'b000));
    end
    step();
    check("R9", "running after settle", 32'(dom_now()), 32'(D_RUN));
    check("R10", "autoref+resume", 32'(pulses_now()), 32'(3'b110));
    step();
    check("R9", "pulses drop", 32'(pulses_now()), 32'(3'b000));
  endtask

  task automatic t_deep_standby(input int n, input int src);
    settle_cycles_i = CNT_W'(n);
    request_sleep(1'b1, 1'b1);
    check("R3", "mode", 32'(mode_o), 32'(2'b11));
    check("R6", "domains", 32'(dom_now()), 32'(D_DSTBY));
    pulse_wake(0);
    check("R8", "irq ignored in deep", 32'(dom_now()), 32'(D_DSTBY));
    pulse_wake(src);
    for (int k = 1; k <= ((n == 0) ? 1 : n); k++) begin
      if (k > 1) step();
      check("R9", "deep settle domains", 32'(dom_now()), 32'(D_SET_DP));
      check("R9", "deep settle mode", 32'(mode_o), 32'(2'b11));
    end
    step();
    check("R9", "running after deep settle", 32'(mode_o), 32'(2'b00));
    check("R10", "autoref+restart", 32'(pulses_now()), 32'(3'b101));
    step();
    check("R10", "pulses drop", 32'(pulses_now()), 32'(3'b000));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_light_sleep();
    t_sw_standby(4, 1);
    t_sw_standby(1, 4);
    t_deep_standby(0, 2);
    t_deep_standby(3, 4);
    t_deep_standby(2, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule